// File: doc/BRIEF.md
# Serial Command Frame Front-End

This block sits between a four-wire serial host port and the command logic of a quad digital-potentiometer controller. The serial clock, data input and active-low chip select each pass through a synchroniser into the system clock domain. The block then counts and captures the bits of each frame. When chip select goes high again, it hands one complete 16-bit word, split into an operation code, an address and a data byte, to the command logic as a single-cycle strobe. A frame that does not hold exactly sixteen bits is dropped.

On the way out, the block presents a word on the serial data output, most significant bit first. By default this is the last accepted frame, so that several devices can be chained. The command logic can replace it for one frame with a readback word. The output models an open-drain pin with an external pull-up: the block pulls it low for a 0 and releases it for a 1, and it never drives it while the device is deselected. The host may idle the clock low or high. Input bits are always taken on rising clock edges, and output bits move on falling edges.

Top module: `spi_frame_front`

## Requirements
- R1: While reset is asserted and right after it, `cmd_valid_o` is 0 and `sdo_drv_low_o` is 0. The chained-output word resets to all ones.
- R2: Bits are sampled on rising edges of `spi_clk_i` while selected, first bit into the MSB. In the 16-bit word, bits 15:12 give `cmd_op_o`, bits 11:8 give `cmd_addr_o` and bits 7:0 give `cmd_data_o`.
- R3: `cmd_valid_o` is high for exactly one system clock. It is raised only in response to chip select going high, and it appears after the third rising system clock edge that follows the rise of `spi_csn_i`.
- R4: If any number of rising clock edges other than 16 was seen while selected (for example 15 or 17), the frame is discarded and no strobe is issued.
- R5: While chip select is high, `sdo_drv_low_o` is 0 (line released).
- R6: While selected, `sdo_drv_low_o` is 1 exactly when the current output bit is 0.
- R7: In a frame, the output presents the word accepted in the previous valid frame, MSB first. Bit i (MSB is bit 0) is present when the host raises the clock for the (i+1)-th time. After the word is used up, the output is all ones.
- R8: With the clock idling high, falling edges before the first rising edge of a frame do not advance the output, so the same bit alignment as in R7 holds.
- R9: A one-cycle `rb_load_i` pulse with `rb_word_i`, given while deselected, makes the next frame present `rb_word_i` in place of the chained word. This holds for that frame only. The frame after it presents the word accepted during the readback frame.
- R10: A discarded frame does not change the chained-output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk_i | input | 1 | Serial clock from host (either idle level) |
| spi_sdi_i | input | 1 | Serial data from host |
| spi_csn_i | input | 1 | Active-low chip select |
| rb_load_i | input | 1 | Strobe from command logic: use rb_word_i for the next frame |
| rb_word_i | input | 16 | Readback word to present |
| cmd_valid_o | output | 1 | One-cycle strobe: a valid frame has been received |
| cmd_op_o | output | 4 | Operation code field |
| cmd_addr_o | output | 4 | Address field |
| cmd_data_o | output | 8 | Data field |
| sdo_drv_low_o | output | 1 | 1 = pull serial output low; 0 = release (high-Z) |

## Verification
Every serial pin reaches the logic through two synchroniser flops and one edge register. The frame strobe therefore appears after the third rising system clock edge after chip select rises. The output bit changes within three system clock edges of a falling serial clock edge. The bench holds each serial clock level for four system clocks and reads the output bit just before it raises the clock. That keeps every captured bit clear of the synchroniser delay. In addition, a behavioural model delays the raw pin values by the same amount and is compared against the strobe, the fields and the output drive on every falling system clock edge.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int FE_FRAME_W = 16;
  localparam int FE_OP_W    = 4;
  localparam int FE_ADR_W   = 4;
  localparam int FE_DAT_W   = FE_FRAME_W - FE_OP_W - FE_ADR_W;
  localparam int FE_CNT_W   = $clog2(FE_FRAME_W + 2);

  typedef logic [FE_FRAME_W-1:0] fe_word_t;

  typedef struct packed {
    logic [FE_OP_W-1:0]  op;
    logic [FE_ADR_W-1:0] addr;
    logic [FE_DAT_W-1:0] data;
  } fe_cmd_t;

  // append one received bit at the LSB end
  function automatic fe_word_t fe_shift_in(fe_word_t w, logic b);
    return {w[FE_FRAME_W-2:0], b};
  endfunction

  // advance the transmit word; released level fills from below
  function automatic fe_word_t fe_shift_out(fe_word_t w);
    return {w[FE_FRAME_W-2:0], 1'b1};
  endfunction

  // saturating edge counter, stops one past a full frame
  function automatic logic [FE_CNT_W-1:0] fe_count_up(logic [FE_CNT_W-1:0] c);
    if (int'(c) > FE_FRAME_W) return c;
    return c + 1'b1;
  endfunction

  function automatic logic fe_frame_full(logic [FE_CNT_W-1:0] c);
    return int'(c) == FE_FRAME_W;
  endfunction

  function automatic fe_cmd_t fe_split(fe_word_t w);
    return fe_cmd_t'(w);
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic q_i,
  output logic rise_o,
  output logic fall_o
);
  logic last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= RST_VAL;
    else        last <= q_i;
  end

  assign rise_o = q_i & ~last;
  assign fall_o = ~q_i & last;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
  import spi_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_i,
  input  logic     sclk_rise_i,
  input  logic     sdi_i,
  input  logic     cs_rise_i,
  input  logic     cs_fall_i,
  output logic     valid_o,
  output fe_cmd_t  cmd_o,
  output fe_word_t echo_o
);
  fe_word_t            shreg;
  logic [FE_CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      valid_o <= 1'b0;
      cmd_o   <= '0;
      echo_o  <= '1;
    end else begin
      valid_o <= 1'b0;
      if (cs_fall_i) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (cs_rise_i) begin
        if (fe_frame_full(cnt)) begin
          valid_o <= 1'b1;
          cmd_o   <= fe_split(shreg);
          echo_o  <= shreg;
        end
      end else if (sel_i && sclk_rise_i) begin
        shreg <= fe_shift_in(shreg, sdi_i);
        cnt   <= fe_count_up(cnt);
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
  import spi_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_i,
  input  logic     cs_fall_i,
  input  logic     cs_rise_i,
  input  logic     sclk_rise_i,
  input  logic     sclk_fall_i,
  input  fe_word_t echo_i,
  input  logic     rb_load_i,
  input  fe_word_t rb_word_i,
  output logic     drv_low_o
);
  fe_word_t txreg;
  fe_word_t rb_hold;
  logic     rb_pend;
  logic     started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg   <= '1;
      rb_hold <= '0;
      rb_pend <= 1'b0;
      started <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        txreg   <= rb_pend ? rb_hold : echo_i;
        rb_pend <= 1'b0;
        started <= 1'b0;
      end else if (cs_rise_i) begin
        txreg <= '1;
      end else if (sel_i) begin
        if (sclk_rise_i)
          started <= 1'b1;
        else if (sclk_fall_i && started)
          txreg <= fe_shift_out(txreg);
      end
      if (rb_load_i) begin
        rb_pend <= 1'b1;
        rb_hold <= rb_word_i;
      end
    end
  end

  assign drv_low_o = sel_i & ~txreg[FE_FRAME_W-1];
endmodule

// File: rtl/spi_frame_front.sv
module spi_frame_front
  import spi_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_clk_i,
  input  logic                  spi_sdi_i,
  input  logic                  spi_csn_i,
  input  logic                  rb_load_i,
  input  logic [FE_FRAME_W-1:0] rb_word_i,
  output logic                  cmd_valid_o,
  output logic [FE_OP_W-1:0]    cmd_op_o,
  output logic [FE_ADR_W-1:0]   cmd_addr_o,
  output logic [FE_DAT_W-1:0]   cmd_data_o,
  output logic                  sdo_drv_low_o
);
  logic     sclk_q, sdi_q, csn_q;
  logic     sclk_rise_evt, sclk_fall_evt;
  logic     cs_rise_evt, cs_fall_evt;
  logic     sel;
  fe_cmd_t  cmd;
  fe_word_t echo_word;

  spi_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d_i(spi_clk_i), .q_o(sclk_q));
  spi_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d_i(spi_sdi_i), .q_o(sdi_q));
  spi_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst_n(rst_n), .d_i(spi_csn_i), .q_o(csn_q));

  spi_fe_edge #(.RST_VAL(1'b0)) u_edge_clk (
    .clk(clk), .rst_n(rst_n), .q_i(sclk_q),
    .rise_o(sclk_rise_evt), .fall_o(sclk_fall_evt));
  spi_fe_edge #(.RST_VAL(1'b1)) u_edge_csn (
    .clk(clk), .rst_n(rst_n), .q_i(csn_q),
    .rise_o(cs_rise_evt), .fall_o(cs_fall_evt));

  assign sel = ~csn_q;

  spi_fe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_rise_i(sclk_rise_evt),
    .sdi_i(sdi_q), .cs_rise_i(cs_rise_evt), .cs_fall_i(cs_fall_evt),
    .valid_o(cmd_valid_o), .cmd_o(cmd), .echo_o(echo_word));

  spi_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cs_fall_i(cs_fall_evt),
    .cs_rise_i(cs_rise_evt), .sclk_rise_i(sclk_rise_evt),
    .sclk_fall_i(sclk_fall_evt), .echo_i(echo_word),
    .rb_load_i(rb_load_i), .rb_word_i(rb_word_i), .drv_low_o(sdo_drv_low_o));

  assign cmd_op_o   = cmd.op;
  assign cmd_addr_o = cmd.addr;
  assign cmd_data_o = cmd.data;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker
  import spi_fe_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic spi_csn_i,
  input logic cmd_valid_o,
  input logic sdo_drv_low_o,
  input logic sel,
  input logic cs_rise_evt,
  input logic cs_fall_evt,
  input logic sclk_rise_evt
);
  logic [5:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      seen <= '0;
    else if (cs_fall_evt)                            seen <= '0;
    else if (sel && sclk_rise_evt && seen != 6'h3f)  seen <= seen + 6'd1;
  end

  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_csn_i, 2) |-> !sdo_drv_low_o); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o); // R3
  AST_STROBE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(cs_rise_evt)); // R3
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (int'($past(seen)) == FE_FRAME_W)); // R4
  AST_SHORT_LONG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_rise_evt) && int'($past(seen)) != FE_FRAME_W) |-> !cmd_valid_o); // R4
endmodule

bind spi_frame_front spi_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn_i(spi_csn_i), .cmd_valid_o(cmd_valid_o),
  .sdo_drv_low_o(sdo_drv_low_o), .sel(sel), .cs_rise_evt(cs_rise_evt),
  .cs_fall_evt(cs_fall_evt), .sclk_rise_evt(sclk_rise_evt));

// File: tb/spi_frame_front_test.sv
module spi_frame_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n, sclk, sdi, csn, rb_load;
  logic [15:0] rb_word;
  logic cmd_valid_o, sdo_drv_low_o;
  logic [3:0] cmd_op_o, cmd_addr_o;
  logic [7:0] cmd_data_o;

  int checks = 0;
  int fails = 0;
  int valid_cnt = 0;
  logic [15:0] last_word = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_front uut (
    .clk(clk), .rst_n(rst_n), .spi_clk_i(sclk), .spi_sdi_i(sdi), .spi_csn_i(csn),
    .rb_load_i(rb_load), .rb_word_i(rb_word), .cmd_valid_o(cmd_valid_o),
    .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .sdo_drv_low_o(sdo_drv_low_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: raw pins delayed as seen after synchronisation
  logic [3:0] hc, hk, hd;
  logic [15:0] m_shift, m_echo, m_tx, m_rbw, m_word;
  int m_cnt;
  bit m_pend, m_started, m_valid, exp_drv;
  bit csf, csr, kr, kf, selm;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '1; hk = '0; hd = '0;
      m_shift = '0; m_echo = '1; m_tx = '1; m_rbw = '0; m_word = '0;
      m_cnt = 0; m_pend = 0; m_started = 0; m_valid = 0; exp_drv = 0;
    end else begin
      csf  = hc[2] && !hc[1];
      csr  = !hc[2] && hc[1];
      kr   = !hk[2] && hk[1];
      kf   = hk[2] && !hk[1];
      selm = !hc[1];
      m_valid = 0;
      if (csf) begin
        m_tx = m_pend ? m_rbw : m_echo;
        m_pend = 0; m_cnt = 0; m_started = 0; m_shift = '0;
      end else if (csr) begin
        m_tx = '1;
        if (m_cnt == 16) begin m_valid = 1; m_word = m_shift; m_echo = m_shift; end
      end else if (selm) begin
        if (kr) begin
          m_shift = {m_shift[14:0], hd[1]};
          if (m_cnt < 17) m_cnt++;
          m_started = 1;
        end else if (kf && m_started) begin
          m_tx = {m_tx[14:0], 1'b1};
        end
      end
      if (rb_load) begin m_pend = 1; m_rbw = rb_word; end
      hc = {hc[2:0], csn};
      hk = {hk[2:0], sclk};
      hd = {hd[2:0], sdi};
      exp_drv = !hc[1] && !m_tx[15];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cmd_valid_o === m_valid, "R3 strobe timing", {31'd0, cmd_valid_o}, {31'd0, m_valid});
      check(sdo_drv_low_o === exp_drv, "R5/R6 output drive", {31'd0, sdo_drv_low_o}, {31'd0, exp_drv});
      if (cmd_valid_o) begin
        valid_cnt++;
        last_word = {cmd_op_o, cmd_addr_o, cmd_data_o};
        check(last_word === m_word, "R2 fields vs model", {16'd0, last_word}, {16'd0, m_word});
      end
    end
  end

  task automatic xfer(input int nbits, input logic [31:0] word, input logic cpol, output logic [31:0] cap);
    cap = '0;
    sclk = cpol;
    repeat (2) @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (cpol) sclk = 1'b0;
      sdi = word[nbits-1-i];
      repeat (HALF) @(negedge clk);
      cap = {cap[30:0], ~sdo_drv_low_o};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!cpol) sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  logic [31:0] cap;
  int vc0;

  initial begin
    rst_n = 0; csn = 1; sclk = 0; sdi = 0; rb_load = 0; rb_word = '0;
    repeat (5) @(negedge clk);
    check(cmd_valid_o === 1'b0, "R1 strobe in reset", {31'd0, cmd_valid_o}, 0);
    check(sdo_drv_low_o === 1'b0, "R1 output in reset", {31'd0, sdo_drv_low_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    xfer(16, 32'hB35A, 1'b0, cap);
    check(valid_cnt == 1, "R3 one strobe", valid_cnt, 1);
    check(last_word === 16'hB35A, "R2 fields", {16'd0, last_word}, 32'hB35A);
    check(cap[15:0] === 16'hFFFF, "R1 reset chained word", cap[15:0], 32'hFFFF);

    xfer(16, 32'h1C7E, 1'b0, cap);
    check(cap[15:0] === 16'hB35A, "R7 chained output", cap[15:0], 32'hB35A);
    check(last_word === 16'h1C7E, "R2 fields", {16'd0, last_word}, 32'h1C7E);

    xfer(16, 32'h9001, 1'b1, cap);
    check(cap[15:0] === 16'h1C7E, "R8 idle-high alignment", cap[15:0], 32'h1C7E);
    check(last_word === 16'h9001, "R2 fields idle-high", {16'd0, last_word}, 32'h9001);
    check(sdo_drv_low_o === 1'b0, "R5 released after frame", {31'd0, sdo_drv_low_o}, 0);

    vc0 = valid_cnt;
    xfer(15, 32'h0ABC, 1'b0, cap);
    check(valid_cnt == vc0, "R4 short frame dropped", valid_cnt, vc0);
    check(cap[14:0] === 15'(16'h9001 >> 1), "R7 partial output", cap[14:0], 32'h9001 >> 1);

    xfer(17, 32'h1FFFF, 1'b1, cap);
    check(valid_cnt == vc0, "R4 long frame dropped", valid_cnt, vc0);
    check(cap[16:1] === 16'h9001, "R10 chained word kept", cap[16:1], 32'h9001);
    check(cap[0] === 1'b1, "R7 ones after word", {31'd0, cap[0]}, 1);

    @(negedge clk); rb_load = 1; rb_word = 16'h2468;
    @(negedge clk); rb_load = 0; rb_word = 16'h0000;
    repeat (3) @(negedge clk);
    xfer(16, 32'h0F0F, 1'b1, cap);
    check(cap[15:0] === 16'h2468, "R9 readback replaces chain", cap[15:0], 32'h2468);
    check(last_word === 16'h0F0F, "R2 fields", {16'd0, last_word}, 32'h0F0F);

    xfer(16, 32'h5555, 1'b0, cap);
    check(cap[15:0] === 16'h0F0F, "R9 readback one frame only", cap[15:0], 32'h0F0F);
    check(valid_cnt == vc0 + 2, "R3 strobe count", valid_cnt, vc0 + 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule